// File: doc/BRIEF.md
# Shared GPIO Interrupt Aggregator

This block folds a bank of general-purpose input pins into a single interrupt request. Pins are grouped into ports. Each port has one polarity bit that selects which level counts as the trigger state for all of its pins. Each pin has its own enable bit. The qualified pin conditions are ORed together. A 0-to-1 transition of that OR sets one pending flip-flop, which raises the shared request toward the interrupt controller. The pending bit stays set until the processor acknowledges it. No pin identity is recorded, so software finds the cause by reading the synchronised pin levels, which the block also provides.

The block has a second mode for a parallel host port. When that mode is selected, host-port events own the request, and every GPIO request is masked, whatever the pin enables say. A single global enable gates the request in both modes. Because the pins share one edge-detected OR, a pin that stays in its trigger state hides later activity on any other pin. That pin must return inactive, or be disabled, before the shared request can fire again.

Top module: `gpio_shared_irq`

## Requirements
- R1: With `rst_n` low on a clock edge, `irq_o` and `pin_status_o` are 0 after that edge.
- R2: `pin_status_o` equals `pin_i` as sampled two clock edges earlier. Pin b of port p is bit p*PORT_WIDTH+b.
- R3: Port p's trigger state is a high level when `pol_i[p]` is 1 and a low level when `pol_i[p]` is 0.
- R4: A pin whose `en_i` bit is 0 cannot set `irq_o` in GPIO mode.
- R5: In GPIO mode with the global enable set, `irq_o` rises on the third clock edge after an enabled pin enters its trigger state from an all-quiet state. While any enabled pin remains in its trigger state, no other pin can raise a new request.
- R6: A new GPIO request becomes possible once every enabled pin is out of its trigger state, or once the blocking pin's enable has been cleared. Re-enabling a pin that is already in its trigger state sets `irq_o` on the next edge.
- R7: `ack_i` clears `irq_o` on the next edge. If a new set condition occurs in the same cycle as the acknowledge, `irq_o` stays 1.
- R8: With `host_mode_i` at 1, GPIO activity never sets `irq_o`. A `host_evt_i` pulse with the global enable set raises `irq_o` on the next edge, regardless of `en_i`.
- R9: With `glob_en_i` at 0, neither mode sets `irq_o`. A GPIO edge that occurs while the global enable is off is not remembered.
- R10: With `host_mode_i` at 0, `host_evt_i` has no effect on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PORTS*PORT_WIDTH | Asynchronous pin levels |
| pol_i | input | NUM_PORTS | Per-port trigger polarity (1 = high is trigger) |
| en_i | input | NUM_PORTS*PORT_WIDTH | Per-pin interrupt enable |
| glob_en_i | input | 1 | Global interrupt gate for both modes |
| host_mode_i | input | 1 | Selects host-port mode, masking GPIO requests |
| host_evt_i | input | 1 | Single-cycle host-port event |
| ack_i | input | 1 | Interrupt acknowledge, clears pending |
| irq_o | output | 1 | Shared pending interrupt request |
| pin_status_o | output | NUM_PORTS*PORT_WIDTH | Synchronised pin levels for software |

## Verification
Properties check on every cycle that the status output is the input delayed by two stages, and that an acknowledge clears pending unless a set coincides. They also check that pending can never rise while the global gate is off, while host mode is on without an event, while host mode is off with no qualified pin, or while the pin OR is held high. Only the bench scenarios can show the three-edge latency from a pin to the request, and the correct polarity and enable selection for each pin and port. The bench scenarios also cover re-arming after a pin goes quiet or is re-enabled, and the loss of an edge that arrives while the global gate is off.

// File: rtl/gpio_shared_irq_pkg.sv
// Package: shared types for the GPIO interrupt aggregator.
// Assumes all control inputs are synchronous to clk.
package gpio_shared_irq_pkg;

    // Number of synchroniser stages applied to pin inputs.
    localparam int SYNC_STAGES = 2;

    // Control bundle passed to the pending stage.
    typedef struct packed {
        logic glob_en;
        logic host_mode;
        logic host_evt;
        logic ack;
    } irq_ctl_t;

endpackage

// File: rtl/gpio_shared_irq_sync.sv
// Module: multi-stage synchroniser for the asynchronous pin levels.
// Assumes inputs may change at any time; outputs are a clean registered copy.
module gpio_shared_irq_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift pin levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] warm_q;
            // Count edges since reset so the delay check never looks before reset.
            always_ff @(posedge clk) begin
                if (!rst_n)            warm_q <= '0;
                else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
            end
            assert_status_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_shared_irq_qualify.sv
// Module: per-port polarity selection, per-pin enable masking and OR reduction.
// Assumes pin levels are already synchronised; purely combinational.
module gpio_shared_irq_qualify #(
    parameter int NUM_PORTS  = 2,
    parameter int PORT_WIDTH = 8,
    localparam int NUM_PINS  = NUM_PORTS * PORT_WIDTH
) (
    input  logic [NUM_PINS-1:0]  lvl_i,
    input  logic [NUM_PORTS-1:0] pol_i,
    input  logic [NUM_PINS-1:0]  en_i,
    output logic                 any_trig_o
);

    logic [NUM_PORTS-1:0] port_hit;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic [PORT_WIDTH-1:0] lv;
            logic [PORT_WIDTH-1:0] trig;
            assign lv   = lvl_i[p*PORT_WIDTH +: PORT_WIDTH];
            // Trigger state is high when polarity is 1, low when 0.
            assign trig = (pol_i[p] ? lv : ~lv) & en_i[p*PORT_WIDTH +: PORT_WIDTH];
            assign port_hit[p] = |trig;
        end
    endgenerate

    assign any_trig_o = |port_hit;

endmodule

// File: rtl/gpio_shared_irq_pending.sv
// Module: edge detection of the qualified OR, mode selection and pending flip-flop.
// Assumes any_trig_i is registered-domain logic and host_evt_i is a one-cycle pulse.
module gpio_shared_irq_pending
    import gpio_shared_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     any_trig_i,
    input  irq_ctl_t ctl_i,
    output logic     pending_o
);

    logic trig_prev_q;
    logic pending_q;
    logic gpio_rise;
    logic gpio_set;
    logic host_set;
    logic set_now;

    // Remember the previous OR value for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev_q <= 1'b0;
        else        trig_prev_q <= any_trig_i;
    end

    assign gpio_rise = any_trig_i & ~trig_prev_q;
    assign gpio_set  = gpio_rise & ctl_i.glob_en & ~ctl_i.host_mode;
    assign host_set  = ctl_i.host_evt & ctl_i.glob_en & ctl_i.host_mode;
    assign set_now   = gpio_set | host_set;

    // Pending flip-flop: set wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending_q <= 1'b0;
        else if (set_now) pending_q <= 1'b1;
        else if (ctl_i.ack) pending_q <= 1'b0;
    end

    assign pending_o = pending_q;

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.ack && !set_now) |=> !pending_q);

    assert_set_beats_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_now |=> pending_q);

    assert_host_masks_gpio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.host_mode && !ctl_i.host_evt && !pending_q) |=> !pending_q);

    assert_global_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_i.glob_en && !pending_q) |=> !pending_q);

    assert_held_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_prev_q && any_trig_i && !ctl_i.host_mode && !pending_q) |=> !pending_q);

    assert_host_evt_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_i.host_mode && !any_trig_i && !pending_q) |=> !pending_q);

endmodule

// File: rtl/gpio_shared_irq.sv
// Module: top of the shared GPIO interrupt aggregator.
// Synchronises pins, qualifies them per port and pin, and drives one pending request.
// Assumes controls are synchronous to clk; pins may be asynchronous.
module gpio_shared_irq
    import gpio_shared_irq_pkg::*;
#(
    parameter int NUM_PORTS  = 2,
    parameter int PORT_WIDTH = 8,
    localparam int NUM_PINS  = NUM_PORTS * PORT_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pin_i,
    input  logic [NUM_PORTS-1:0] pol_i,
    input  logic [NUM_PINS-1:0]  en_i,
    input  logic                 glob_en_i,
    input  logic                 host_mode_i,
    input  logic                 host_evt_i,
    input  logic                 ack_i,
    output logic                 irq_o,
    output logic [NUM_PINS-1:0]  pin_status_o
);

    logic [NUM_PINS-1:0] pin_sync;
    logic                any_trig;
    irq_ctl_t            ctl;

    gpio_shared_irq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    gpio_shared_irq_qualify #(
        .NUM_PORTS  (NUM_PORTS),
        .PORT_WIDTH (PORT_WIDTH)
    ) u_qual (
        .lvl_i      (pin_sync),
        .pol_i      (pol_i),
        .en_i       (en_i),
        .any_trig_o (any_trig)
    );

    // Bundle the control inputs for the pending stage.
    always_comb begin
        ctl.glob_en   = glob_en_i;
        ctl.host_mode = host_mode_i;
        ctl.host_evt  = host_evt_i;
        ctl.ack       = ack_i;
    end

    gpio_shared_irq_pending u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_trig_i (any_trig),
        .ctl_i      (ctl),
        .pending_o  (irq_o)
    );

    assign pin_status_o = pin_sync;

endmodule

// File: tb/gpio_shared_irq_tb.sv
`timescale 1ns/1ps
module gpio_shared_irq_tb;
    localparam int NP = 2;
    localparam int PW = 4;
    localparam int N  = NP * PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]  pins = '0;
    logic [N-1:0]  en = '0;
    logic [NP-1:0] pol = '0;
    logic glob_en = 1'b0, host_mode = 1'b0, host_evt = 1'b0, ack = 1'b0;
    logic irq;
    logic [N-1:0] status;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpio_shared_irq #(.NUM_PORTS(NP), .PORT_WIDTH(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .pol_i(pol), .en_i(en),
        .glob_en_i(glob_en), .host_mode_i(host_mode), .host_evt_i(host_evt),
        .ack_i(ack), .irq_o(irq), .pin_status_o(status));

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] idle_lv(input logic [NP-1:0] p);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = ~p[i/PW];
        return v;
    endfunction

    task automatic settle();
        pins = idle_lv(pol);
        step(4);
        ack = 1'b1; step(1); ack = 1'b0;
    endtask

    task automatic pulse_host();
        host_evt = 1'b1; step(1); host_evt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        check("R1 irq in reset", irq, 0);
        check("R1 status in reset", status, 0);
        rst_n = 1'b1;
        // R2: two-stage delay of pin levels
        pins = 8'hA5; step(1);
        check("R2 one edge", status, 8'h00);
        step(1);
        check("R2 two edges", status, 8'hA5);
        pins = 8'h5A; step(2);
        check("R2 second pattern", status, 8'h5A);

        // R3/R4/R5 sweep over every pin and every polarity combination
        glob_en = 1'b1;
        for (int pv = 0; pv < (1 << NP); pv++) begin
            for (int i = 0; i < N; i++) begin
                en = '0; pol = pv[NP-1:0]; settle();
                en = N'(1) << i; step(1);
                pins[i] = pol[i/PW]; step(2);
                check("R5 latency not yet", irq, 0);
                step(1);
                check("R3 trigger level sets irq", irq, 1);
                en = '0; settle();
                en = ~(N'(1) << i); step(1);
                pins[i] = pol[i/PW]; step(3);
                check("R4 disabled pin ignored", irq, 0);
            end
        end

        // R5/R6 blocking and re-arming
        en = '0; pol = '1; settle();
        en = '1; step(1);
        pins[0] = 1'b1; step(3);
        check("R5 first pin", irq, 1);
        ack = 1'b1; step(1); ack = 1'b0;
        check("R7 ack clears", irq, 0);
        pins[5] = 1'b1; step(3);
        check("R5 second pin blocked", irq, 0);
        pins[0] = 1'b0; step(3);
        check("R5 still blocked by other pin", irq, 0);
        en[5] = 1'b0; step(2);
        en[5] = 1'b1; step(1);
        check("R6 re-enable rearms", irq, 1);
        ack = 1'b1; step(1); ack = 1'b0;
        pins[5] = 1'b0; step(3);
        pins[5] = 1'b1; step(3);
        check("R6 quiet then new edge", irq, 1);
        ack = 1'b1; step(1); ack = 1'b0;

        // R7 acknowledge coinciding with a new set
        pins = '0; step(4);
        pins[2] = 1'b1; step(2);
        ack = 1'b1; step(1); ack = 1'b0;
        check("R7 set beats ack", irq, 1);
        step(1);
        check("R7 stays pending", irq, 1);
        ack = 1'b1; step(1); ack = 1'b0;
        check("R7 later ack clears", irq, 0);

        // R8 host-port mode
        pins = '0; host_mode = 1'b1; step(4);
        pins[1] = 1'b1; step(3);
        check("R8 gpio masked", irq, 0);
        pulse_host();
        check("R8 host event", irq, 1);
        ack = 1'b1; step(1); ack = 1'b0;
        en = '0; pulse_host();
        check("R8 host ignores enables", irq, 1);
        ack = 1'b1; step(1); ack = 1'b0;

        // R9 global gate
        glob_en = 1'b0; pulse_host();
        check("R9 host gated", irq, 0);
        host_mode = 1'b0; en = '1; pins = '0; step(4);
        pins[6] = 1'b1; step(3);
        check("R9 gpio gated", irq, 0);
        glob_en = 1'b1; step(3);
        check("R9 edge not remembered", irq, 0);

        // R10 host event outside host mode
        pins = '0; step(4);
        pulse_host(); step(1);
        check("R10 host event ignored", irq, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule